// File: doc/BRIEF.md
# UART Transmit Holding and Shift Path

This block is the transmit half of a serial port. A host places one byte at a time into a holding register with a write strobe. When the shifter is free, that byte moves across into the shift register. It then leaves on the serial line as a frame: a low start bit, the data bits with the least significant bit first, and a high stop bit. Every bit lasts a fixed number of pulses of an oversampling tick enable. Two flags feed a line-status register. `thr_empty` tells the host it may write another byte. `tx_empty` tells it that the line has gone quiet.

The path has two stages. The holding register is freed in the same clock in which its byte enters the shifter, so the host can queue a second byte while the first is still on the wire. A queued byte starts on the clock after the previous stop bit ends, with no idle gap. A write that arrives while the holding register is occupied is dropped, and the pending byte is kept.

The shifter is a four-state machine. `TX_IDLE` keeps the line high and waits for a full holding register. The transition "load" takes the byte and enters `TX_START`, which drives the line low. The transition "start done" enters `TX_DATA`, which shifts out one data bit per bit period. The transition "last data bit done" enters `TX_STOP`, which drives the line high. The transition "stop done" returns to `TX_IDLE`, and from there a waiting byte is loaded on the next clock.

Top module: `uart_tx_path`

## Requirements
- R1: While reset is asserted and just after it is released, `thr_empty` = 1, `tx_empty` = 1 and `txd` = 1.
- R2: A write with `wr_en` = 1 while `thr_empty` = 1 captures `wr_data`, and `thr_empty` reads 0 on the following cycle.
- R3: With the shifter idle, a held byte is loaded into the shifter on the next clock edge. `thr_empty` returns to 1 in that cycle and `txd` drops to 0 (the start bit).
- R4: A write while `thr_empty` = 0 is ignored. The pending byte is neither replaced nor duplicated, and `thr_empty` stays 0.
- R5: `tx_empty` is 1 only when both the holding register and the shifter are empty, it falls only after an accepted write, and `txd` is 1 whenever `tx_empty` is 1.
- R6: A frame consists of one low start bit, then DATA_W data bits with bit 0 first, then one high stop bit.
- R7: Every bit lasts exactly OVS pulses of `tick`. `txd` changes only on a clock edge that carries a tick or a load.
- R8: A byte queued during a frame is sent right after that frame's stop bit. Bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, OVS pulses per bit |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| txd | output | 1 | Serial output, high when idle |
| thr_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The bench builds the block with DATA_W = 8 and OVS = 4, and drives `tick` once every three clocks. With four ticks per bit, each frame takes about 120 clocks. That is short enough to cover isolated bytes, all-zero and single-set-bit patterns, a write dropped while the holding register is full, and chains of back-to-back frames within a short run. The shortened oversampling ratio still leaves a middle of each bit to sample and a tick counter that wraps more than once, so bit-length errors move the sampled values and are caught.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Single-entry holding stage; a write is accepted only while empty.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/uart_tx_tickcnt.sv
module uart_tx_tickcnt #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_done
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = tick && !clr && (cnt == LAST);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              bit_done,
    output logic              take,
    output logic              idle,
    output logic              txd
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (hold_full) state_d = TX_START;
            TX_START: if (bit_done)  state_d = TX_DATA;
            TX_DATA:  if (bit_done && bitcnt == LAST_BIT) state_d = TX_STOP;
            TX_STOP:  if (bit_done)  state_d = TX_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                shreg  <= hold_data;
                bitcnt <= '0;
            end else if (state_q == TX_DATA && bit_done) begin
                shreg  <= shreg >> 1;
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        take = 1'b0;
        idle = 1'b0;
        txd  = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                idle = 1'b1;
                take = hold_full;
            end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_q;
    logic              load;
    logic              shift_idle;
    logic              bit_done;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (hold_q)
    );

    uart_tx_tickcnt #(.OVS(OVS)) u_tickcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .tick     (tick),
        .bit_done (bit_done)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_full (hold_full),
        .hold_data (hold_q),
        .bit_done  (bit_done),
        .take      (load),
        .idle      (shift_idle),
        .txd       (txd)
    );

    assign thr_empty = !hold_full;
    assign tx_empty  = !hold_full && shift_idle;

endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              txd,
    input logic              thr_empty,
    input logic              tx_empty,
    input logic [DATA_W-1:0] hold_q,
    input logic              shift_idle,
    input logic              load
);

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && thr_empty) |=> !thr_empty);                          // R2

    AST_THR_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_empty && shift_idle) |=> thr_empty);                     // R3

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_empty |=> $stable(hold_q));                               // R4

    AST_TXE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en));                             // R5

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);                                             // R5

    AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> ($past(tick) || $past(load)));               // R7

endmodule

bind uart_tx_path uart_tx_path_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .txd        (txd),
    .thr_empty  (thr_empty),
    .tx_empty   (tx_empty),
    .hold_q     (hold_q),
    .shift_idle (shift_idle),
    .load       (load)
);

// File: tb/uart_tx_path_bench.sv
module uart_tx_path_bench;

    localparam int DATA_W = 8;
    localparam int OVS    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              txd, thr_empty, tx_empty;

    int checks = 0;
    int failures = 0;
    int frames = 0;
    int pushed = 0;
    bit finished = 0;
    logic [DATA_W-1:0] exp_q[$];

    always #4 clk = ~clk;

    uart_tx_path #(.DATA_W(DATA_W), .OVS(OVS)) u_uart_tx_path (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Tick generator: one pulse every three clocks
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == 2) ? 0 : div + 1;
            tick = (div == 0);
        end
    end

    // Driver: issues a write and queues the byte if acceptance is expected
    task automatic host_write(input logic [DATA_W-1:0] b, input bit accept);
        check(thr_empty == accept, accept ? "R2 pre-write flag" : "R4 pre-write flag",
              32'(thr_empty), 32'(accept));
        wr_en = 1'b1;
        wr_data = b;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (accept) begin
            exp_q.push_back(b);
            pushed++;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!(tx_empty && exp_q.size() == 0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, "R8 drain", 32'(n), 32'd5000);
    endtask

    task automatic wait_thr();
        int n = 0;
        while (!thr_empty && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Monitor: samples each bit in its middle and compares with the scoreboard
    initial begin
        int nt;
        logic [DATA_W-1:0] got;
        logic [DATA_W-1:0] exp;
        forever begin
            @(negedge clk);
            if (!rst_n || txd) continue;
            nt = 0;
            got = '0;
            for (int b = 0; b < DATA_W + 2; b++) begin
                while (nt < b * OVS + OVS / 2) begin
                    @(posedge clk);
                    if (tick) nt++;
                end
                @(negedge clk);
                if (b == 0)
                    check(txd == 1'b0, "R6 start bit", 32'(txd), 32'd0);
                else if (b <= DATA_W)
                    got[b-1] = txd;
                else
                    check(txd == 1'b1, "R6 stop bit", 32'(txd), 32'd1);
            end
            frames++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected frame", 32'(got), 32'hFFFF);
            end else begin
                exp = exp_q.pop_front();
                check(got == exp, "R6/R7/R8 frame data", 32'(got), 32'(exp));
            end
            while (nt < (DATA_W + 2) * OVS) begin
                @(posedge clk);
                if (tick) nt++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(thr_empty == 1'b1, "R1 thr_empty", 32'(thr_empty), 32'd1);
        check(tx_empty == 1'b1, "R1 tx_empty", 32'(tx_empty), 32'd1);
        check(txd == 1'b1, "R1 txd", 32'(txd), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(thr_empty && tx_empty && txd, "R1 after release",
              {29'd0, thr_empty, tx_empty, txd}, 32'd7);

        // R2/R3: single byte
        host_write(8'hA5, 1'b1);
        check(thr_empty == 1'b0, "R2 holding full", 32'(thr_empty), 32'd0);
        check(tx_empty == 1'b0, "R5 busy after write", 32'(tx_empty), 32'd0);
        @(negedge clk);
        check(thr_empty == 1'b1, "R3 holding freed", 32'(thr_empty), 32'd1);
        check(tx_empty == 1'b0, "R5 shifter busy", 32'(tx_empty), 32'd0);
        check(txd == 1'b0, "R3 start bit begins", 32'(txd), 32'd0);

        // R8: queue behind; R4: write while full dropped
        host_write(8'h3C, 1'b1);
        check(thr_empty == 1'b0, "R2 second byte held", 32'(thr_empty), 32'd0);
        repeat (5) @(negedge clk);
        host_write(8'hFF, 1'b0);
        check(thr_empty == 1'b0, "R4 flag unchanged", 32'(thr_empty), 32'd0);
        wait_idle();
        check(frames == 2, "R4 frame count", 32'(frames), 32'd2);

        // R6: assorted patterns one at a time
        foreach (pat_list[i]) begin
            host_write(pat_list[i], 1'b1);
            wait_idle();
        end

        // R8: back-to-back chain
        host_write(8'hC3, 1'b1);
        @(negedge clk);
        host_write(8'h96, 1'b1);
        wait_thr();
        host_write(8'h69, 1'b1);
        wait_idle();

        repeat (10) @(negedge clk);
        check(tx_empty == 1'b1 && txd == 1'b1, "R5 idle at end",
              {30'd0, tx_empty, txd}, 32'd3);
        check(frames == pushed, "R8 all frames sent", 32'(frames), 32'(pushed));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [DATA_W-1:0] pat_list [4] = '{8'h00, 8'h80, 8'h01, 8'h5A};

endmodule